// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Front-End

This block is the clocked control front-end of a single-port burst SRAM that shares one data bus for reads and writes. Each word is split into byte lanes of nine bits: eight data bits and one parity bit. On every rising clock edge the block decodes two address strobes, three chip enables and the write controls. It captures the address, performs a one-cycle write of whole words or of selected lanes into an internal register array, and decides whether the shared bus is driven by the array. The address and a load pulse go to an external burst counter in the cycle an access starts. The advance request is passed on to that counter in all other cycles.

A small state machine tracks the access in flight. Its states are `ST_IDLE` (no access), `ST_CAPT` (read address captured, array being read), `ST_DRIVE` (read word ready on the output register) and `ST_WROTE` (a write completed on the last edge). Its transitions are as follows. A deselect moves any state to `ST_IDLE`. A write start moves any state to `ST_WROTE`. A read start moves any state to `ST_CAPT`. With no strobe, `ST_CAPT` goes to `ST_DRIVE`, `ST_DRIVE` stays in `ST_DRIVE`, `ST_WROTE` goes to `ST_IDLE`, and `ST_IDLE` stays in `ST_IDLE`.

Top module: `sbsram_front`

## Requirements
- R1: After reset the bus drive enable `dq_drv` is 0, the output register `dq_out` is 0, and no burst load is signalled while both strobes are high.
- R2: A write happens only when, on one edge, `ctl_stb_n` is 0, `cpu_stb_n` is 1, the chip is selected (`en_a_n`=0, `en_b`=1, `en_c_n`=0) and the write controls select at least one lane. If any of these is missing, the array is unchanged.
- R3: With `all_wr_n`=0 all 18 bits at `addr` take `dq_in`, whatever `lane_wr_n` and `lane_sel_n` are.
- R4: With `all_wr_n`=1 and `lane_wr_n`=0, lane k (bits 9k+8..9k, where bit 9k+8 is its parity) is written exactly when `lane_sel_n[k]`=0. The other lane keeps its contents.
- R5: When both strobes are 0 with the chip selected, the processor strobe wins: the cycle is a read and nothing is written.
- R6: In any cycle that decodes as a write, `dq_drv` is 0, even with `out_en_n`=0 and a read word pending.
- R7: A read captured on edge T shows `dq_drv`=0 until edge T+1. From edge T+1 it presents the stored word on `dq_out` with `dq_drv`=1, provided `out_en_n`=0.
- R8: `dq_drv` is never 1 while `out_en_n` is 1.
- R9: In a cycle that starts an access, `burst_load`=1, `burst_addr` equals `addr`, and `burst_step` is 0 even if `adv_n` is 0. In other cycles `burst_step` is the inverse of `adv_n`.
- R10: A selected strobe with `all_wr_n`=1, and either `lane_wr_n`=1 or both `lane_sel_n` bits 1, is a read and writes nothing.
- R11: A strobe with the chip not selected moves the block to idle. From the next edge `dq_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| adv_n | input | 1 | Burst advance request, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| dq_in | input | LANES*LANE_W | Write data from the shared bus |
| dq_out | output | LANES*LANE_W | Read data toward the shared bus |
| dq_drv | output | 1 | Bus driver enable for `dq_out` |
| burst_load | output | 1 | Load pulse to the burst counter |
| burst_addr | output | AW | Start address to the burst counter |
| burst_step | output | 1 | Advance pulse to the burst counter |

## Verification
The checker watches, on every cycle, the rules that hold at the ports: the bus is off in any decoded write cycle, the bus is off whenever output enable is high, the bus is off in the cycle after a read capture or a deselect, and the advance is suppressed while an access starts. What lands in the array can only be seen through the bench's scenarios. These cover whole-word writes that override lane selects, single-lane writes that keep the other lane intact, writes blocked by a missing enable or strobe, strobe priority, and empty lane masks. Each case is read back against an independent shadow memory.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_WROTE = 2'd3
    } sb_state_t;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode #(
    parameter int LANES = 2
) (
    input  logic             ctl_stb_n,
    input  logic             cpu_stb_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             adv_n,
    output logic             rd_start,
    output logic             wr_start,
    output logic             desel,
    output logic [LANES-1:0] lane_mask,
    output logic             burst_load,
    output logic             burst_step
);
    logic chip_on;
    logic any_stb;

    always_comb begin
        chip_on = !en_a_n && en_b && !en_c_n;
        any_stb = !ctl_stb_n || !cpu_stb_n;
        if (!all_wr_n)
            lane_mask = '1;
        else if (!lane_wr_n)
            lane_mask = ~lane_sel_n;
        else
            lane_mask = '0;
        wr_start   = chip_on && cpu_stb_n && !ctl_stb_n && (|lane_mask);
        rd_start   = chip_on && any_stb && !wr_start;
        desel      = any_stb && !chip_on;
        burst_load = rd_start || wr_start;
        burst_step = !adv_n && !burst_load;
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_lane[k])
                lane_mem[wr_addr] <= wr_data[k*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (rd_en)
                lane_q <= lane_mem[rd_addr];
        end

        assign rd_data[k*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/sbsram_fsm.sv
module sbsram_fsm
    import sbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_start,
    input  logic          wr_start,
    input  logic          desel,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_q,
    output logic          rd_en,
    output logic          dq_drv
);
    sb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (desel)
            state_d = ST_IDLE;
        else if (wr_start)
            state_d = ST_WROTE;
        else if (rd_start)
            state_d = ST_CAPT;
        else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CAPT:  state_d = ST_DRIVE;
                ST_DRIVE: state_d = ST_DRIVE;
                ST_WROTE: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_start || wr_start)
                addr_q <= addr;
        end
    end

    always_comb begin
        rd_en  = 1'b0;
        dq_drv = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CAPT:  rd_en = 1'b1;
            ST_DRIVE: dq_drv = !out_en_n && !wr_start;
            ST_WROTE: ;
        endcase
    end
endmodule

// File: rtl/sbsram_front.sv
module sbsram_front #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_stb_n,
    input  logic              cpu_stb_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              adv_n,
    input  logic              out_en_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drv,
    output logic              burst_load,
    output logic [AW-1:0]     burst_addr,
    output logic              burst_step
);
    logic             rd_start;
    logic             wr_start;
    logic             desel;
    logic [LANES-1:0] lane_mask;
    logic [AW-1:0]    addr_q;
    logic             rd_en;
    logic [LANES-1:0] wr_lane;

    sbsram_decode #(.LANES(LANES)) u_decode (
        .ctl_stb_n  (ctl_stb_n),
        .cpu_stb_n  (cpu_stb_n),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .adv_n      (adv_n),
        .rd_start   (rd_start),
        .wr_start   (wr_start),
        .desel      (desel),
        .lane_mask  (lane_mask),
        .burst_load (burst_load),
        .burst_step (burst_step)
    );

    sbsram_fsm #(.AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .desel    (desel),
        .out_en_n (out_en_n),
        .addr     (addr),
        .addr_q   (addr_q),
        .rd_en    (rd_en),
        .dq_drv   (dq_drv)
    );

    assign wr_lane    = wr_start ? lane_mask : '0;
    assign burst_addr = addr;

    sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (wr_lane),
        .wr_addr (addr),
        .wr_data (dq_in),
        .rd_en   (rd_en),
        .rd_addr (addr_q),
        .rd_data (dq_out)
    );
endmodule

// File: rtl/sbsram_front_chk.sv
module sbsram_front_chk #(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_stb_n,
    input logic             cpu_stb_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             all_wr_n,
    input logic             lane_wr_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             out_en_n,
    input logic             dq_drv,
    input logic             burst_load,
    input logic             burst_step
);
    // R6
    bus_off_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && cpu_stb_n && !en_a_n && en_b && !en_c_n &&
         (!all_wr_n || (!lane_wr_n && lane_sel_n != '1))) |-> !dq_drv);

    // R8
    oe_gates_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drv |-> !out_en_n);

    // R9
    start_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_load |-> !burst_step);

    // R7
    capture_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !en_a_n && en_b && !en_c_n) |=> !dq_drv);

    // R11
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctl_stb_n || !cpu_stb_n) && (en_a_n || !en_b || en_c_n)) |=> !dq_drv);
endmodule

bind sbsram_front sbsram_front_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_stb_n  (ctl_stb_n),
    .cpu_stb_n  (cpu_stb_n),
    .en_a_n     (en_a_n),
    .en_b       (en_b),
    .en_c_n     (en_c_n),
    .all_wr_n   (all_wr_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .out_en_n   (out_en_n),
    .dq_drv     (dq_drv),
    .burst_load (burst_load),
    .burst_step (burst_step)
);

// File: tb/sbsram_front_bench.sv
module sbsram_front_bench;
    localparam int AW = 6;
    localparam int W  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_stb_n = 1'b1, cpu_stb_n = 1'b1;
    logic          en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [1:0]    lane_sel_n = 2'b11;
    logic          adv_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  dq_in = '0;
    logic [W-1:0]  dq_out;
    logic          dq_drv, burst_load, burst_step;
    logic [AW-1:0] burst_addr;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] model [1<<AW];
    logic [W-1:0] exp_q [$];
    logic prev_drv = 1'b0;
    logic finished = 1'b0;

    always #5ns clk = ~clk;

    sbsram_front u_sbsram_front (
        .clk(clk), .rst_n(rst_n), .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .all_wr_n(all_wr_n),
        .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .adv_n(adv_n),
        .out_en_n(out_en_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_drv(dq_drv), .burst_load(burst_load), .burst_addr(burst_addr),
        .burst_step(burst_step)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ctl_stb_n = 1'b1; cpu_stb_n = 1'b1;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 2'b11; adv_n = 1'b1;
    endtask

    // Monitor: pops an expected word whenever the bus drive rises (R7)
    always begin
        @(negedge clk);
        #2ns;
        if (rst_n && dq_drv && !prev_drv) begin
            if (exp_q.size() == 0) check("R7 unexpected drive", 18'h1, 18'h0);
            else check("R7 read data", dq_out, exp_q.pop_front());
        end
        prev_drv = dq_drv;
    end

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic g_n,
                      input logic bw_n, input logic [1:0] sel_n, input logic ea_n,
                      input logic eb, input logic ec_n, input logic cpu_n, input logic oe_n);
        logic chips;
        logic [1:0] m;
        logic wr_go;
        @(negedge clk);
        ctl_stb_n = 1'b0; cpu_stb_n = cpu_n; en_a_n = ea_n; en_b = eb; en_c_n = ec_n;
        all_wr_n = g_n; lane_wr_n = bw_n; lane_sel_n = sel_n; addr = a; dq_in = d;
        out_en_n = oe_n; adv_n = 1'b0;
        chips = !ea_n && eb && !ec_n;
        m = !g_n ? 2'b11 : (!bw_n ? ~sel_n : 2'b00);
        wr_go = chips && cpu_n && (m != 2'b00);
        #3ns;
        if (wr_go) check("R6 bus off in write", {17'b0, dq_drv}, 18'h0);
        check("R9 load on start", {17'b0, burst_load}, {17'b0, chips});
        check("R9 step blocked", {17'b0, burst_step}, {17'b0, !chips});
        if (chips) check("R9 load addr", {12'b0, burst_addr}, {12'b0, a});
        if (wr_go) begin
            if (m[0]) model[a][8:0]  = d[8:0];
            if (m[1]) model[a][17:9] = d[17:9];
        end
        @(negedge clk);
        go_idle();
        out_en_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic use_cpu, input logic keep_oe);
        @(negedge clk);
        go_idle();
        if (use_cpu) cpu_stb_n = 1'b0; else ctl_stb_n = 1'b0;
        addr = a;
        exp_q.push_back(model[a]);
        @(negedge clk);
        go_idle();
        out_en_n = 1'b0;
        #3ns check("R7 no drive in capture cycle", {17'b0, dq_drv}, 18'h0);
        @(negedge clk);
        @(negedge clk);
        if (!keep_oe) out_en_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3ns;
        check("R1 drive after reset", {17'b0, dq_drv}, 18'h0);
        check("R1 data after reset", dq_out, 18'h0);
        check("R1 no load after reset", {17'b0, burst_load}, 18'h0);

        @(negedge clk); adv_n = 1'b0;
        #3ns check("R9 step follows advance", {17'b0, burst_step}, 18'h1);
        @(negedge clk); go_idle();

        // R3 whole-word writes, including override of lane selects
        wr(3, 18'h2A5A5, 0, 1, 2'b11, 0, 1, 0, 1, 1);
        rd(3, 0, 0);
        wr(3, 18'h15A5A, 0, 0, 2'b10, 0, 1, 0, 1, 1);
        rd(3, 0, 0);

        // R4 single-lane writes
        wr(5, 18'h3FFFF, 0, 1, 2'b11, 0, 1, 0, 1, 1);
        wr(5, 18'h00000, 1, 0, 2'b01, 0, 1, 0, 1, 1);
        rd(5, 0, 0);
        wr(5, 18'h12345, 1, 0, 2'b10, 0, 1, 0, 1, 1);
        rd(5, 1, 0);

        // R2 any missing condition blocks the write
        wr(7, 18'h0AAAA, 0, 1, 2'b11, 0, 1, 0, 1, 1);
        wr(7, 18'h00000, 0, 1, 2'b11, 1, 1, 0, 1, 1);
        wr(7, 18'h00000, 0, 1, 2'b11, 0, 0, 0, 1, 1);
        wr(7, 18'h00000, 0, 1, 2'b11, 0, 1, 1, 1, 1);
        @(negedge clk); addr = 7; dq_in = '0; all_wr_n = 1'b0;
        @(negedge clk); go_idle();
        rd(7, 0, 0);

        // R5 processor strobe wins over a controller write
        wr(7, 18'h00000, 0, 1, 2'b11, 0, 1, 0, 0, 1);
        rd(7, 0, 0);

        // R10 empty lane masks are reads
        wr(7, 18'h00000, 1, 0, 2'b11, 0, 1, 0, 1, 1);
        wr(7, 18'h00000, 1, 1, 2'b00, 0, 1, 0, 1, 1);
        rd(7, 0, 0);

        // R8 output enable high: never driven
        @(negedge clk); go_idle(); ctl_stb_n = 1'b0; addr = 7;
        @(negedge clk); go_idle();
        @(negedge clk); #3ns check("R8 no drive with oe high", {17'b0, dq_drv}, 18'h0);
        @(negedge clk); #3ns check("R8 still no drive", {17'b0, dq_drv}, 18'h0);

        // R6 write while a read word is on the bus
        wr(9, 18'h2BEEF, 0, 1, 2'b11, 0, 1, 0, 1, 1);
        rd(9, 0, 1);
        #3ns check("R6 bus driven before write", {17'b0, dq_drv}, 18'h1);
        wr(9, 18'h1CAFE, 0, 1, 2'b11, 0, 1, 0, 1, 0);
        rd(9, 0, 0);

        // R11 deselect releases the bus
        wr(11, 18'h00F0F, 0, 1, 2'b11, 0, 1, 0, 1, 1);
        rd(11, 0, 1);
        @(negedge clk); ctl_stb_n = 1'b0; en_b = 1'b0;
        #3ns check("R11 driven before deselect edge", {17'b0, dq_drv}, 18'h1);
        @(negedge clk); go_idle();
        #3ns check("R11 released after deselect", {17'b0, dq_drv}, 18'h0);
        @(negedge clk); out_en_n = 1'b1;

        repeat (3) @(negedge clk);
        check("R7 all reads seen", 18'(exp_q.size()), 18'h0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule